// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block decides which clocks of a small processor subsystem may run. It divides the incoming oscillator clock by two to form the internal clock, groups six internal periods into a machine cycle, and drives three enables: one for the oscillator, one for the peripherals and interrupt logic, and one for the processor core. Software selects a low-power mode by writing a two-bit power-control field. Bit 0 requests idle and bit 1 requests power-down.

In idle, only the core clock stops. A pending interrupt brings the core back at the next machine-cycle boundary. In power-down, all three enables drop and interrupts are ignored. Only a reset that the block has qualified ends that state. The external reset request is active high. It becomes the internal system reset only after it has stayed high for two full machine cycles. A recognized reset returns the block to the running state with every clock enabled.

The divider runs from the always-present input clock. This lets the block time a reset while the oscillator enable is low.

Top module: `pwrclk_ctrl`

## Requirements
- R1: `mcyc_end` is a one-cycle pulse. It repeats every CLK_DIV*MC_STATES input cycles, which is 12 with the default parameters.
- R2: While `por_n` is low and after it is released, `osc_en`, `per_clk_en` and `cpu_clk_en` are all 1 and `sys_rst` is 0.
- R3: A write with bit 0 = 1 and bit 1 = 0 while running is idle entry. From the write edge, `cpu_clk_en` is 0 while `osc_en` and `per_clk_en` stay 1.
- R4: In idle, a pulse on `irq_pend` is remembered. `cpu_clk_en` returns to 1 at the first machine-cycle boundary at or after the edge that samples the interrupt, and not before.
- R5: A write with bit 1 = 1 while running is power-down entry, and it drives all three enables to 0. An interrupt has no effect in power-down. Only a recognized reset ends it.
- R6: `sys_rst` rises only after `ext_rst` has been held high for 2*6 internal clock ticks, which is 23 to 24 input cycles. A shorter pulse is ignored. `sys_rst` falls one cycle after `ext_rst` goes low.
- R7: One cycle after `sys_rst` rises, both modes are cleared and all three enables are 1. This holds whether the block was in idle or in power-down.
- R8: A write with both bits set enters power-down and not idle.
- R9: Writes are ignored while the core is stopped (idle or power-down) and while `sys_rst` is high. A write of 0 while running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Oscillator clock, always present |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External reset request, active high, qualified before use |
| irq_pend | input | 1 | Pending-interrupt indication from the interrupt logic |
| pcon_we | input | 1 | Write strobe of the power-control field |
| pcon_wdata | input | 2 | Write data: bit 0 idle request, bit 1 power-down request |
| osc_en | output | 1 | Oscillator enable |
| per_clk_en | output | 1 | Peripheral and interrupt-logic clock enable |
| cpu_clk_en | output | 1 | Processor core clock enable |
| mcyc_end | output | 1 | Last input cycle of each machine cycle |
| sys_rst | output | 1 | Qualified system reset |

## Verification
A write changes the enables at the edge that samples the write. The bench therefore checks them at the next falling edge.

An idle wake-up is due at the first edge on which `mcyc_end` is high at or after the edge that samples the interrupt. The bench reads `mcyc_end` before each edge. It expects the core enable to stay 0 until that edge and to be 1 just after it.

Reset recognition can land on either of two edges, depending on the divider phase. The bench therefore accepts only a 23 or 24 cycle latency. It confirms that a 22-cycle pulse never raises `sys_rst`, and it checks the enables two cycles after a reset has been released.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10
  } pwr_mode_e;

  // internal ticks a reset request must be held before it is accepted
  function automatic int unsigned qual_ticks(int unsigned mcycles, int unsigned states);
    return mcycles * states;
  endfunction

  // input-clock cycles in one machine cycle
  function automatic int unsigned mc_period(int unsigned div, int unsigned states);
    return div * states;
  endfunction

  // power-down wins when both requests are set
  function automatic pwr_mode_e decode_req(logic idle_req, logic pd_req);
    if (pd_req)   return MODE_PD;
    if (idle_req) return MODE_IDLE;
    return MODE_RUN;
  endfunction

endpackage

// File: rtl/pwrclk_divider.sv
module pwrclk_divider #(
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned MC_STATES = 6
) (
  input  logic clk_in,
  input  logic por_n,
  output logic int_tick,
  output logic mc_end
);
  localparam int unsigned SW = (MC_STATES > 1) ? $clog2(MC_STATES) : 1;
  localparam logic [SW-1:0] ST_LAST = SW'(MC_STATES - 1);

  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign int_tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_in or negedge por_n) begin
        if (!por_n)                div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign int_tick = (div_q == DIV_LAST);
    end
  endgenerate

  logic [SW-1:0] st_q;
  always_ff @(posedge clk_in or negedge por_n) begin
    if (!por_n) st_q <= '0;
    else if (int_tick) begin
      if (st_q == ST_LAST) st_q <= '0;
      else                 st_q <= st_q + 1'b1;
    end
  end

  assign mc_end = int_tick && (st_q == ST_LAST);
endmodule

// File: rtl/pwrclk_rst_qual.sv
module pwrclk_rst_qual #(
  parameter int unsigned LIMIT = 12
) (
  input  logic clk_in,
  input  logic por_n,
  input  logic ext_rst,
  input  logic int_tick,
  output logic rst_ok
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_in or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      rst_ok <= 1'b0;
    end else if (!ext_rst) begin
      cnt_q  <= '0;
      rst_ok <= 1'b0;
    end else if (int_tick && !rst_ok) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) rst_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrclk_mode_ctrl.sv
module pwrclk_mode_ctrl
  import pwrclk_pkg::*;
(
  input  logic      clk_in,
  input  logic      por_n,
  input  logic      sys_rst,
  input  logic      mc_end,
  input  logic      irq_pend,
  input  logic      wr_accept,
  input  logic      req_idle,
  input  logic      req_pd,
  output pwr_mode_e mode_q,
  output logic      wake_hit
);
  logic wake_q;

  assign wake_hit = (mode_q == MODE_IDLE) && mc_end && (wake_q || irq_pend);

  always_ff @(posedge clk_in or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
    end else if (sys_rst) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
    end else if (wr_accept) begin
      mode_q <= decode_req(req_idle, req_pd);
      wake_q <= 1'b0;
    end else if (wake_hit) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
    end else if (mode_q == MODE_IDLE && irq_pend) begin
      wake_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrclk_ctrl.sv
module pwrclk_ctrl
  import pwrclk_pkg::*;
#(
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned MC_STATES = 6,
  parameter int unsigned RST_MC    = 2,
  parameter int unsigned IDLE_BIT  = 0,
  parameter int unsigned PD_BIT    = 1
) (
  input  logic       clk_in,
  input  logic       por_n,
  input  logic       ext_rst,
  input  logic       irq_pend,
  input  logic       pcon_we,
  input  logic [1:0] pcon_wdata,
  output logic       osc_en,
  output logic       per_clk_en,
  output logic       cpu_clk_en,
  output logic       mcyc_end,
  output logic       sys_rst
);
  localparam int unsigned QUAL_LIMIT = qual_ticks(RST_MC, MC_STATES);

  logic      int_tick;
  logic      mc_end;
  logic      wr_accept;
  logic      wake_hit;
  pwr_mode_e mode_q;

  pwrclk_divider #(.CLK_DIV(CLK_DIV), .MC_STATES(MC_STATES)) u_div (
    .clk_in(clk_in), .por_n(por_n), .int_tick(int_tick), .mc_end(mc_end)
  );

  pwrclk_rst_qual #(.LIMIT(QUAL_LIMIT)) u_qual (
    .clk_in(clk_in), .por_n(por_n), .ext_rst(ext_rst),
    .int_tick(int_tick), .rst_ok(sys_rst)
  );

  assign wr_accept = pcon_we && !sys_rst && (mode_q == MODE_RUN);

  pwrclk_mode_ctrl u_mode (
    .clk_in(clk_in), .por_n(por_n), .sys_rst(sys_rst), .mc_end(mc_end),
    .irq_pend(irq_pend), .wr_accept(wr_accept),
    .req_idle(pcon_wdata[IDLE_BIT]), .req_pd(pcon_wdata[PD_BIT]),
    .mode_q(mode_q), .wake_hit(wake_hit)
  );

  assign osc_en     = (mode_q != MODE_PD);
  assign per_clk_en = (mode_q != MODE_PD);
  assign cpu_clk_en = (mode_q == MODE_RUN);
  assign mcyc_end   = mc_end;
endmodule

// File: rtl/pwrclk_ctrl_chk.sv
module pwrclk_ctrl_chk #(
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned MC_STATES = 6,
  parameter int unsigned RST_MC    = 2,
  parameter int unsigned IDLE_BIT  = 0,
  parameter int unsigned PD_BIT    = 1
) (
  input logic       clk_in,
  input logic       por_n,
  input logic       ext_rst,
  input logic       irq_pend,
  input logic       pcon_we,
  input logic [1:0] pcon_wdata,
  input logic       osc_en,
  input logic       per_clk_en,
  input logic       cpu_clk_en,
  input logic       mc_end,
  input logic       sys_rst,
  input logic       wake_hit
);
  localparam logic [15:0] PERIOD   = 16'(CLK_DIV * MC_STATES);
  localparam logic [15:0] MIN_HOLD = 16'(CLK_DIV * RST_MC * MC_STATES - 1);

  logic [15:0] hold_cnt;
  logic [15:0] gap_cnt;
  logic        seen_mc;

  always_ff @(posedge clk_in or negedge por_n) begin
    if (!por_n) begin
      hold_cnt <= '0;
      gap_cnt  <= '0;
      seen_mc  <= 1'b0;
    end else begin
      if (!ext_rst)              hold_cnt <= '0;
      else if (hold_cnt != '1)   hold_cnt <= hold_cnt + 1'b1;
      if (mc_end) begin
        gap_cnt <= '0;
        seen_mc <= 1'b1;
      end else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_MC_PERIOD: assert property (@(posedge clk_in) disable iff (!por_n)
    mc_end && seen_mc |-> gap_cnt == PERIOD - 1); // R1

  AST_IDLE_ENTRY: assert property (@(posedge clk_in) disable iff (!por_n)
    pcon_we && cpu_clk_en && !sys_rst && pcon_wdata[IDLE_BIT] && !pcon_wdata[PD_BIT]
    |=> !cpu_clk_en && per_clk_en && osc_en); // R3

  AST_WAKE_ON_BOUNDARY: assert property (@(posedge clk_in) disable iff (!por_n)
    $rose(cpu_clk_en) |-> $past(mc_end) || $past(sys_rst)); // R4

  AST_WAKE_TAKEN: assert property (@(posedge clk_in) disable iff (!por_n)
    wake_hit && !sys_rst |=> cpu_clk_en); // R4

  AST_PD_STICKY: assert property (@(posedge clk_in) disable iff (!por_n)
    !osc_en && !sys_rst |=> !osc_en && !cpu_clk_en); // R5

  AST_RST_HELD: assert property (@(posedge clk_in) disable iff (!por_n)
    $rose(sys_rst) |-> hold_cnt >= MIN_HOLD); // R6

  AST_RST_RELEASE: assert property (@(posedge clk_in) disable iff (!por_n)
    !ext_rst |=> !sys_rst); // R6

  AST_RST_CLEARS: assert property (@(posedge clk_in) disable iff (!por_n)
    $rose(sys_rst) |=> osc_en && per_clk_en && cpu_clk_en); // R7

  AST_PD_PRECEDENCE: assert property (@(posedge clk_in) disable iff (!por_n)
    pcon_we && cpu_clk_en && !sys_rst && pcon_wdata[PD_BIT]
    |=> !osc_en && !per_clk_en && !cpu_clk_en); // R8

  AST_WRITE_WHILE_IDLE: assert property (@(posedge clk_in) disable iff (!por_n)
    !cpu_clk_en && osc_en && !sys_rst && !mc_end |=> osc_en); // R9

  always_comb begin
    if (por_n === 1'b0) begin
      AST_POR_STATE: assert (osc_en && per_clk_en && cpu_clk_en && !sys_rst); // R2
    end
  end

  logic unused_ok;
  assign unused_ok = irq_pend;
endmodule

bind pwrclk_ctrl pwrclk_ctrl_chk #(
  .CLK_DIV(CLK_DIV), .MC_STATES(MC_STATES), .RST_MC(RST_MC),
  .IDLE_BIT(IDLE_BIT), .PD_BIT(PD_BIT)
) u_chk (
  .clk_in(clk_in), .por_n(por_n), .ext_rst(ext_rst), .irq_pend(irq_pend),
  .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .osc_en(osc_en),
  .per_clk_en(per_clk_en), .cpu_clk_en(cpu_clk_en), .mc_end(mc_end),
  .sys_rst(sys_rst), .wake_hit(wake_hit)
);

// File: tb/pwrclk_ctrl_bench.sv
module pwrclk_ctrl_bench;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst = 1'b0;
  logic       irq_pend = 1'b0;
  logic       pcon_we = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic       osc_en, per_clk_en, cpu_clk_en, mcyc_end, sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwrclk_ctrl u_pwrclk_ctrl (
    .clk_in(clk), .por_n(por_n), .ext_rst(ext_rst), .irq_pend(irq_pend),
    .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .osc_en(osc_en),
    .per_clk_en(per_clk_en), .cpu_clk_en(cpu_clk_en), .mcyc_end(mcyc_end),
    .sys_rst(sys_rst)
  );

  // table entry: [7:6] op, [5:4] write data, [2:0] expected {osc, per, cpu}
  localparam logic [1:0] OP_WR = 2'd0, OP_IRQ = 2'd1, OP_RST = 2'd2, OP_WAIT = 2'd3;
  localparam int NVEC = 13;
  localparam logic [7:0] VEC [NVEC] = '{
    {OP_WR,   2'b00, 1'b0, 3'b111},  // R9 write of zero while running
    {OP_WR,   2'b01, 1'b0, 3'b110},  // R3 idle entry
    {OP_WAIT, 2'b00, 1'b0, 3'b110},  // R3 idle stays without an interrupt
    {OP_WR,   2'b10, 1'b0, 3'b110},  // R9 write ignored in idle
    {OP_IRQ,  2'b00, 1'b0, 3'b111},  // R4 interrupt wakes idle
    {OP_WR,   2'b10, 1'b0, 3'b000},  // R5 power-down entry
    {OP_IRQ,  2'b00, 1'b0, 3'b000},  // R5 interrupt ignored
    {OP_RST,  2'b00, 1'b0, 3'b111},  // R7 reset leaves power-down
    {OP_WR,   2'b11, 1'b0, 3'b000},  // R8 both bits
    {OP_WR,   2'b01, 1'b0, 3'b000},  // R9 write ignored in power-down
    {OP_RST,  2'b00, 1'b0, 3'b111},  // R7
    {OP_WR,   2'b01, 1'b0, 3'b110},  // R3
    {OP_RST,  2'b00, 1'b0, 3'b111}   // R7 reset leaves idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] enables();
    return {osc_en, per_clk_en, cpu_clk_en};
  endfunction

  function automatic string op_tag(logic [1:0] op);
    case (op)
      OP_WR:   return "R3/R5/R8/R9 write";
      OP_IRQ:  return "R4/R5 interrupt";
      OP_RST:  return "R7 reset";
      default: return "R3 wait";
    endcase
  endfunction

  task automatic do_write(input logic [1:0] d);
    @(negedge clk);
    pcon_we = 1'b1;
    pcon_wdata = d;
    @(negedge clk);
    pcon_we = 1'b0;
    pcon_wdata = 2'b00;
  endtask

  task automatic do_irq();
    @(negedge clk);
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic do_reset(input int hold);
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (hold) @(negedge clk);
    ext_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int n;
    bit seen;
    logic m;

    #5;
    check("R2 enables during por", 32'(enables()), 32'h7);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 enables after por", 32'(enables()), 32'h7);
    check("R2 sys_rst after por", 32'(sys_rst), 32'h0);

    // R1 machine-cycle period
    do @(negedge clk); while (!mcyc_end);
    n = 0;
    do begin @(negedge clk); n++; end while (!mcyc_end && n < 40);
    check("R1 machine cycle length", 32'(n), 32'd12);
    @(negedge clk);
    check("R1 strobe width", 32'(mcyc_end), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][7:6])
        OP_WR:   do_write(VEC[i][5:4]);
        OP_IRQ:  do_irq();
        OP_RST:  do_reset(30);
        default: repeat (30) @(negedge clk);
      endcase
      check(op_tag(VEC[i][7:6]), 32'(enables()), 32'(VEC[i][2:0]));
    end

    // R4 wake lands exactly on the machine-cycle boundary
    for (int k = 0; k < 3; k++) begin
      do_write(2'b01);
      repeat (3 + 4 * k) @(negedge clk);
      irq_pend = 1'b1;
      n = 0;
      seen = 1'b0;
      while (!seen && n < 20) begin
        m = mcyc_end;
        @(negedge clk);
        irq_pend = 1'b0;
        n++;
        if (m) begin
          seen = 1'b1;
          check("R4 core enable at boundary", 32'(cpu_clk_en), 32'h1);
        end else if (cpu_clk_en) begin
          check("R4 core enable before boundary", 32'(cpu_clk_en), 32'h0);
        end
      end
      check("R4 boundary reached within one machine cycle", 32'(seen && n <= 12), 32'h1);
    end

    // R6 recognition latency
    @(negedge clk);
    ext_rst = 1'b1;
    n = 0;
    while (!sys_rst && n < 40) begin @(negedge clk); n++; end
    check("R6 reset latency in 23..24", 32'(n >= 23 && n <= 24), 32'h1);
    ext_rst = 1'b0;
    @(negedge clk);
    check("R6 sys_rst release", 32'(sys_rst), 32'h0);

    // R6 short pulse ignored, power-down kept
    do_write(2'b10);
    @(negedge clk);
    ext_rst = 1'b1;
    seen = 1'b0;
    for (int j = 0; j < 22; j++) begin
      @(negedge clk);
      if (sys_rst) seen = 1'b1;
    end
    ext_rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 short pulse not recognized", 32'(seen), 32'h0);
    check("R6 short pulse keeps power-down", 32'(enables()), 32'h0);
    do_reset(30);
    check("R7 recovery", 32'(enables()), 32'h7);

    // R9 write during recognized reset ignored
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (28) @(negedge clk);
    pcon_we = 1'b1;
    pcon_wdata = 2'b10;
    @(negedge clk);
    pcon_we = 1'b0;
    pcon_wdata = 2'b00;
    ext_rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 write during reset", 32'(enables()), 32'h7);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule